// File: doc/BRIEF.md
# Dual-Mask Interrupt Priority Controller

This block keeps the two interrupt mask bits of a processor's condition-code register and decides which interrupt request the CPU takes. One mask bit (X) gates a single high-priority pin request. The other (I) gates a vector of ordinary request lines. An illegal-opcode trap request is gated by neither bit and ranks above everything else.

The CPU sequencer raises `boundary_i` at each instruction boundary. On that cycle at most one pending request is accepted. The block then pulses `accept_o` for one cycle and drives the winner's code on `src_o`. The masks do not change at acceptance. They change when the sequencer reports through `stack_done_i` that the condition-code byte has been saved. The update depends on the class of the request that was taken. A return-from-interrupt loads both bits from the saved byte. Software may write the masks, but it can only clear X and never set it again.

Top module: `dual_mask_irq_ctrl`

## Requirements
- R1: After reset, `x_mask_o`=1, `i_mask_o`=1 and `accept_o`=0. With both masks set, neither the pin request nor any ordinary request is accepted.
- R2: A software write (`sw_wr_i`=1) loads I from `sw_i_i`. It clears X when `sw_x_i`=0. Writing 1 to X while X is 0 leaves X at 0.
- R3: When X is 0, the pin request is accepted whatever the value of I, with code 1. It outranks every ordinary request.
- R4: Ordinary requests are accepted only while I is 0. The lowest asserted index wins, and its code is 2 plus that index.
- R5: The trap request is accepted whatever the values of X and I, with code 0. It outranks the pin request.
- R6: Requests are sampled only on a cycle with `boundary_i`=1 and no entry outstanding. `accept_o` is high for exactly the one cycle after that edge. `src_o` holds its value until the next acceptance.
- R7: When an ordinary or trap entry completes (`stack_done_i`), I becomes 1 and X is unchanged.
- R8: When a pin entry completes (`stack_done_i`), both X and I become 1.
- R9: A return (`rti_i`=1) loads X from `rti_x_i` and I from `rti_i_i`.
- R10: In one cycle, entry completion takes precedence over a return, and a return takes precedence over a software write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary from the sequencer |
| trap_req_i | input | 1 | Illegal-opcode trap request |
| pin_req_i | input | 1 | High-priority request, gated by X |
| irq_req_i | input | N_IRQ | Ordinary requests, gated by I |
| sw_wr_i | input | 1 | Software write strobe for the masks |
| sw_x_i | input | 1 | Written X value (clear only) |
| sw_i_i | input | 1 | Written I value |
| stack_done_i | input | 1 | Condition-code byte saved for the current entry |
| rti_i | input | 1 | Return-from-interrupt strobe |
| rti_x_i | input | 1 | X from the saved byte |
| rti_i_i | input | 1 | I from the saved byte |
| accept_o | output | 1 | One-cycle acceptance strobe |
| src_o | output | SRC_W | Code of the accepted source |
| x_mask_o | output | 1 | Current X mask |
| i_mask_o | output | 1 | Current I mask |

## Verification
The hardest state to reach from the ports is X set again after software has cleared it. Software cannot set X, so the bench clears X, takes a pin request, and completes the entry with `stack_done_i` to return X to 1. It then uses a return to bring back the cleared masks, and shows that a trap entry leaves X at 0. Same-cycle collisions are forced directly: a software write lands on the entry-completion edge, and a boundary arrives while an entry is still outstanding.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    // Fixed source codes; ordinary requests start at SRC_ORD_BASE
    localparam int SRC_TRAP     = 0;
    localparam int SRC_PIN      = 1;
    localparam int SRC_ORD_BASE = 2;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_ORD  = 2'd1,
        CLS_PIN  = 2'd2
    } entry_cls_e;

    typedef struct packed {
        logic x;
        logic i;
    } mask_t;
endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N_REQ = 8,
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = N_REQ - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/mask_bits.sv
module mask_bits
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr_i,
    input  logic sw_x_i,
    input  logic sw_i_i,
    input  logic rti_i,
    input  logic rti_x_i,
    input  logic rti_i_i,
    input  logic entry_done_i,
    input  logic entry_pin_i,
    output logic x_o,
    output logic i_o
);
    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (sw_wr_i) begin
            m_d.i = sw_i_i;
            m_d.x = m_q.x & sw_x_i;
        end
        if (rti_i) begin
            m_d.x = rti_x_i;
            m_d.i = rti_i_i;
        end
        if (entry_done_i) begin
            m_d.i = 1'b1;
            if (entry_pin_i) begin
                m_d.x = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{x: 1'b1, i: 1'b1};
        end else begin
            m_q <= m_d;
        end
    end

    assign x_o = m_q.x;
    assign i_o = m_q.i;

    // R2
    x_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && !m_q.x && !rti_i && !entry_done_i) |=> !m_q.x);

    // R9
    rti_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_i && !entry_done_i) |=> (m_q.x == $past(rti_x_i) && m_q.i == $past(rti_i_i)));
endmodule

// File: rtl/dual_mask_irq_ctrl.sv
module dual_mask_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int SRC_W = $clog2(N_IRQ + SRC_ORD_BASE),
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             trap_req_i,
    input  logic             pin_req_i,
    input  logic [N_IRQ-1:0] irq_req_i,
    input  logic             sw_wr_i,
    input  logic             sw_x_i,
    input  logic             sw_i_i,
    input  logic             stack_done_i,
    input  logic             rti_i,
    input  logic             rti_x_i,
    input  logic             rti_i_i,
    output logic             accept_o,
    output logic [SRC_W-1:0] src_o,
    output logic             x_mask_o,
    output logic             i_mask_o
);
    typedef struct packed {
        entry_cls_e       cls;
        logic             accept;
        logic [SRC_W-1:0] src;
    } arb_t;

    arb_t s_d, s_q;

    logic             ord_any;
    logic [IDX_W-1:0] ord_idx;
    logic             entry_done;
    logic             x_q, i_q;

    irq_lowest_pick #(.N_REQ(N_IRQ)) i_pick (
        .req_i (irq_req_i),
        .any_o (ord_any),
        .idx_o (ord_idx)
    );

    assign entry_done = stack_done_i && (s_q.cls != CLS_NONE);

    mask_bits i_masks (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_wr_i      (sw_wr_i),
        .sw_x_i       (sw_x_i),
        .sw_i_i       (sw_i_i),
        .rti_i        (rti_i),
        .rti_x_i      (rti_x_i),
        .rti_i_i      (rti_i_i),
        .entry_done_i (entry_done),
        .entry_pin_i  (s_q.cls == CLS_PIN),
        .x_o          (x_q),
        .i_o          (i_q)
    );

    always_comb begin
        s_d = s_q;
        s_d.accept = 1'b0;
        if (entry_done) begin
            s_d.cls = CLS_NONE;
        end
        if (boundary_i && s_q.cls == CLS_NONE) begin
            if (trap_req_i) begin
                s_d.accept = 1'b1;
                s_d.src    = SRC_W'(SRC_TRAP);
                s_d.cls    = CLS_ORD;
            end else if (pin_req_i && !x_q) begin
                s_d.accept = 1'b1;
                s_d.src    = SRC_W'(SRC_PIN);
                s_d.cls    = CLS_PIN;
            end else if (ord_any && !i_q) begin
                s_d.accept = 1'b1;
                s_d.src    = SRC_W'(ord_idx) + SRC_W'(SRC_ORD_BASE);
                s_d.cls    = CLS_ORD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cls: CLS_NONE, accept: 1'b0, src: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign accept_o = s_q.accept;
    assign src_o    = s_q.src;
    assign x_mask_o = x_q;
    assign i_mask_o = i_q;

    // R6
    accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o);

    // R6
    accept_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(boundary_i));

    // R3
    pin_gated_by_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && src_o == SRC_W'(SRC_PIN)) |-> !$past(x_mask_o));

    // R4
    ord_gated_by_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && src_o >= SRC_W'(SRC_ORD_BASE)) |-> !$past(i_mask_o));

    // R8
    x_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(x_mask_o) |-> $past(rti_i || (stack_done_i && s_q.cls == CLS_PIN)));

    // R7
    entry_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |=> i_mask_o);
endmodule

// File: tb/test_dual_mask_irq_ctrl.sv
module test_dual_mask_irq_ctrl;
    localparam int N = 8;
    localparam int SW = $clog2(N + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary = 0, trap = 0, pin = 0, sw_wr = 0, sw_x = 0, sw_i = 0;
    logic stack_done = 0, rti = 0, rti_x = 0, rti_i = 0;
    logic [N-1:0] irq = '0;
    logic accept, x_m, i_m;
    logic [SW-1:0] src;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    dual_mask_irq_ctrl #(.N_IRQ(N)) i_dual_mask_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .trap_req_i(trap),
        .pin_req_i(pin), .irq_req_i(irq), .sw_wr_i(sw_wr), .sw_x_i(sw_x),
        .sw_i_i(sw_i), .stack_done_i(stack_done), .rti_i(rti),
        .rti_x_i(rti_x), .rti_i_i(rti_i), .accept_o(accept), .src_o(src),
        .x_mask_o(x_m), .i_mask_o(i_m)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        boundary = 0; trap = 0; pin = 0; irq = '0; sw_wr = 0;
        stack_done = 0; rti = 0;
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 0;
        cyc();
        cyc();
        rst_n = 1;
        cyc();
    endtask

    task automatic write_masks(input logic x, input logic i);
        sw_wr = 1; sw_x = x; sw_i = i;
        cyc();
        sw_wr = 0;
    endtask

    task automatic finish_entry();
        stack_done = 1;
        cyc();
        stack_done = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(x_m, 1, "R1 x after reset");
        chk(i_m, 1, "R1 i after reset");
        chk(accept, 0, "R1 accept after reset");
        pin = 1; irq = 8'hFF; boundary = 1;
        cyc();
        quiet();
        chk(accept, 0, "R1 masked requests ignored");
    endtask

    task automatic t_ordinary();
        do_reset();
        write_masks(1, 0);
        chk(x_m, 1, "R2 x kept");
        chk(i_m, 0, "R2 i cleared");
        irq = 8'b0010_1000; boundary = 1;
        cyc();
        boundary = 0;
        chk(accept, 1, "R4 accept ordinary");
        chk(src, 5, "R4 lowest index code");
        cyc();
        chk(accept, 0, "R6 one-cycle strobe");
        chk(src, 5, "R6 src holds");
        boundary = 1;
        cyc();
        boundary = 0;
        chk(accept, 0, "R6 no accept while entry outstanding");
        finish_entry();
        chk(i_m, 1, "R7 i set on entry");
        chk(x_m, 1, "R7 x unchanged");
        boundary = 1;
        cyc();
        quiet();
        chk(accept, 0, "R4 gated by i");
    endtask

    task automatic t_x_sticky();
        do_reset();
        write_masks(0, 1);
        chk(x_m, 0, "R2 x cleared");
        write_masks(1, 1);
        chk(x_m, 0, "R2 x not set by software");
        chk(i_m, 1, "R2 i written");
    endtask

    task automatic t_pin();
        do_reset();
        write_masks(0, 1);
        pin = 1; irq = 8'h01; boundary = 1;
        cyc();
        quiet();
        chk(accept, 1, "R3 pin accepted with i set");
        chk(src, 1, "R3 pin code");
        finish_entry();
        chk(x_m, 1, "R8 x set on pin entry");
        chk(i_m, 1, "R8 i set on pin entry");
        rti = 1; rti_x = 0; rti_i = 0;
        cyc();
        rti = 0;
        chk(x_m, 0, "R9 x restored");
        chk(i_m, 0, "R9 i restored");
        pin = 1; irq = 8'h01; boundary = 1;
        cyc();
        quiet();
        chk(accept, 1, "R3 accept with both clear");
        chk(src, 1, "R3 pin outranks ordinary");
        finish_entry();
    endtask

    task automatic t_trap();
        do_reset();
        trap = 1; pin = 1; boundary = 1;
        cyc();
        quiet();
        chk(accept, 1, "R5 trap accepted while masked");
        chk(src, 0, "R5 trap code");
        finish_entry();
        rti = 1; rti_x = 0; rti_i = 0;
        cyc();
        rti = 0;
        trap = 1; pin = 1; irq = 8'h80; boundary = 1;
        cyc();
        quiet();
        chk(src, 0, "R5 trap outranks pin");
        finish_entry();
        chk(i_m, 1, "R7 trap entry sets i");
        chk(x_m, 0, "R7 trap entry keeps x");
    endtask

    task automatic t_no_boundary();
        do_reset();
        write_masks(0, 0);
        irq = 8'h04; pin = 1;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk(accept, 0, "R6 no sampling off boundary");
        end
        quiet();
    endtask

    task automatic t_precedence();
        do_reset();
        write_masks(0, 0);
        pin = 1; boundary = 1;
        cyc();
        quiet();
        stack_done = 1; sw_wr = 1; sw_x = 0; sw_i = 0;
        rti = 1; rti_x = 0; rti_i = 0;
        cyc();
        quiet();
        chk(x_m, 1, "R10 entry beats return and write on x");
        chk(i_m, 1, "R10 entry beats return and write on i");
        rti = 1; rti_x = 0; rti_i = 1; sw_wr = 1; sw_x = 0; sw_i = 0;
        cyc();
        quiet();
        chk(i_m, 1, "R10 return beats write");
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_ordinary();
                t_x_sticky();
                t_pin();
                t_trap();
                t_no_boundary();
                t_precedence();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule